// File: doc/BRIEF.md
# Synchronous Programmable One-Shot Timer

This block converts a rising edge on an asynchronous trigger line into one clean output pulse whose length is a programmable number of clock periods. The trigger first crosses into the clock domain through a chain of synchronizing flip-flops. A registered edge detector then produces a single-cycle start strobe. A two-state controller captures the pulse length from the delay input, loads a down-counter and holds the output high until the counter reaches zero.

The controller has two states. IDLE holds the output low. ACTIVE holds it high. The transition *fire* (IDLE to ACTIVE) is taken when a start strobe arrives and the delay input is non-zero; the counter is loaded with the delay minus one. The transition *expire* (ACTIVE to IDLE) is taken when the counter holds zero. In every other case each state holds: IDLE waits, and ACTIVE decrements the counter and ignores start strobes. The end of the pulse is found by comparing against the constant zero, never against a variable value. Both pulse edges are therefore aligned to the clock, and the start lags the trigger by between zero and one clock period of quantization.

Top module: `oneshot_timer`

## Requirements
- R1: When the trigger is low at a rising clock edge and high at the next one, the output goes high right after the third rising edge that samples it high. The latency from trigger to output is exactly three clocks.
- R2: A delay value D, from 1 to 2^CNT_W-1, gives exactly D consecutive clock cycles of high output. CNT_W defaults to 8, so D=255 gives 255 cycles.
- R3: A trigger edge that is accepted while the delay input is zero gives no output pulse. The output stays low.
- R4: The delay input is sampled only on the clock edge that starts the pulse. Changing it while the pulse runs does not change that pulse's length.
- R5: Trigger edges detected while the output is high are ignored. A trigger held high for any length of time gives exactly one pulse.
- R6: A trigger edge whose start strobe falls on the first clock after the pulse ends is accepted. Two pulses can then be separated by a single low cycle.
- R7: A trigger that is high for a single clock period is caught and gives a full pulse.
- R8: Synchronous reset clears the synchronizer, the edge detector, the counter and the state. The output is low in the cycle after reset. A trigger edge that is still in the synchronizer when reset arrives is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high, for start-up only |
| trig_i | input | 1 | Asynchronous trigger; a rising edge requests a pulse |
| delay_i | input | CNT_W | Pulse length in clock periods, sampled at pulse start |
| pulse_o | output | 1 | Output pulse, high while the one-shot is active |

## Verification
The hardest case is the boundary between the end of one pulse and the start of the next. A start strobe one cycle too early falls on the *expire* transition and must be lost. One cycle later it must be accepted. To reach it, the bench raises the trigger exactly four clock cycles after starting a three-cycle pulse, so that the strobe lands on the first IDLE cycle. A scoreboard then expects a second pulse separated by a single low cycle. Retriggering in the middle of a pulse, and a trigger edge that is cut off by reset while still in the synchronizer, are placed at cycle-exact offsets in the same way.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Controller states of the one-shot
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } os_state_e;

endpackage

// File: rtl/trig_sync.sv
// Multi-stage synchronizer: the asynchronous input drives only the first flop.
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[s] <= 1'b0;
                    else       chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/rise_detect.sv
// Registered rising-edge detector on an already synchronized level.
module rise_detect (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic rise_o
);

    logic level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) level_q <= 1'b0;
        else       level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/pulse_core.sv
// Two-state controller with a down-counter that terminates on constant zero.
module pulse_core
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    os_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             load_en, dec_en;

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Transitions: fire (IDLE->ACTIVE), expire (ACTIVE->IDLE)
    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        dec_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && (delay_i != CNT_ZERO)) begin
                    state_d = ST_ACTIVE;
                    load_en = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (cnt_q == CNT_ZERO) state_d = ST_IDLE;
                else                   dec_en  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Down-counter
    always_ff @(posedge clk_i) begin
        if (rst_i)        cnt_q <= CNT_ZERO;
        else if (load_en) cnt_q <= delay_i - CNT_ONE;
        else if (dec_en)  cnt_q <= cnt_q - CNT_ONE;
    end

    // Output decode
    always_comb begin
        pulse_o = (state_q == ST_ACTIVE);
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             pulse_o
);

    logic trig_sync;
    logic trig_rise;

    trig_sync #(.STAGES(SYNC_STAGES)) sync_u (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (trig_i),
        .sync_o  (trig_sync)
    );

    rise_detect edge_u (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (trig_sync),
        .rise_o  (trig_rise)
    );

    pulse_core #(.CNT_W(CNT_W)) core_u (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (trig_rise),
        .delay_i (delay_i),
        .pulse_o (pulse_o)
    );

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             trig_i,
    input logic [CNT_W-1:0] delay_i,
    input logic             pulse_o
);

    logic             seen_q;
    logic [CNT_W-1:0] dly_d;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W:0]   run_q;

    // Measures the high run of the output and the delay in force when it began
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_q <= 1'b0;
            dly_d  <= '0;
            len_q  <= '0;
            run_q  <= '0;
        end else begin
            seen_q <= pulse_o;
            dly_d  <= delay_i;
            if (pulse_o && !seen_q) begin
                run_q <= {{CNT_W{1'b0}}, 1'b1};
                len_q <= dly_d;
            end else if (pulse_o) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1: output rises three clocks after a trigger rise
    p_latency_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pulse_o) |-> ($past(trig_i, 3) && !$past(trig_i, 4)));

    // R2, R4, R5: high run equals the delay captured at start
    p_length_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pulse_o) |-> (run_q == {1'b0, len_q}));

    // R3: a pulse never starts with a zero delay
    p_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pulse_o) |-> ($past(delay_i) != '0));

    // R8: output low right after reset
    p_reset_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !pulse_o);

endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .trig_i  (trig_i),
    .delay_i (delay_i),
    .pulse_o (pulse_o)
);

// File: tb/oneshot_timer_tb_top.sv
`timescale 1ns/1ps
module oneshot_timer_tb_top;

    localparam int CNT_W = 8;

    typedef struct {
        int    start;
        int    len;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig = 1'b0;
    logic [CNT_W-1:0] dly = '0;
    logic             pulse;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    pulses_seen = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    oneshot_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .trig_i  (trig),
        .delay_i (dly),
        .pulse_o (pulse)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: raise trigger, hold for 'hold' cycles, push expected pulse
    task automatic fire(input int d, input int hold, input string tag);
        @(negedge clk);
        dly  = d[CNT_W-1:0];
        trig = 1'b1;
        if (d != 0) exp_q.push_back('{start: cyc + 3, len: d, tag: tag});
        repeat (hold) @(negedge clk);
        trig = 1'b0;
    endtask

    // Monitor: measures each output pulse and compares to the scoreboard
    initial begin
        bit prev = 1'b0;
        int st = 0;
        int ln = 0;
        forever begin
            @(negedge clk);
            if (pulse && !prev) begin
                st = cyc;
                ln = 1;
            end else if (pulse) begin
                ln++;
            end
            if (!pulse && prev) begin
                pulses_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected pulse start", st, -1);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(st == it.start, it.tag, "pulse start cycle", st, it.start);
                    check(ln == it.len, it.tag, "pulse length", ln, it.len);
                end
            end
            prev = pulse;
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check(pulse == 1'b0, "R8", "output during reset", pulse, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(pulse == 1'b0, "R8", "output after reset", pulse, 0);

        // R1 R2 R7: single-cycle trigger, several lengths
        fire(5, 1, "R1");
        repeat (12) @(negedge clk);
        fire(1, 1, "R7");
        repeat (8) @(negedge clk);
        fire(255, 1, "R2");
        repeat (262) @(negedge clk);

        // R3: zero delay gives nothing
        base = pulses_seen;
        fire(0, 1, "R3");
        repeat (10) @(negedge clk);
        check(pulses_seen == base && pulse == 1'b0, "R3", "pulses after zero delay",
              pulses_seen - base, 0);

        // R4: delay changes mid-pulse
        fire(6, 1, "R4");
        repeat (4) @(negedge clk);
        dly = 8'd2;
        repeat (10) @(negedge clk);
        dly = 8'd40;
        repeat (3) @(negedge clk);
        check(pulse == 1'b0, "R4", "output after pulse with changed delay", pulse, 0);

        // R5: retrigger during pulse, then held-high trigger
        base = pulses_seen;
        fire(10, 1, "R5");
        repeat (3) @(negedge clk);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (15) @(negedge clk);
        fire(4, 30, "R5");
        repeat (8) @(negedge clk);
        check(pulses_seen - base == 2, "R5", "pulses from retrigger and hold",
              pulses_seen - base, 2);

        // R6: strobe on first idle cycle after expiry
        fire(3, 1, "R6");
        repeat (2) @(negedge clk);
        fire(4, 1, "R6");
        repeat (12) @(negedge clk);

        // R8: trigger cut off by reset while in the synchronizer
        base = pulses_seen;
        @(negedge clk); trig = 1'b1; dly = 8'd7;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); trig = 1'b0;
        check(pulse == 1'b0, "R8", "output in reset", pulse, 0);
        @(negedge clk); rst = 1'b0;
        repeat (15) @(negedge clk);
        check(pulses_seen == base && pulse == 1'b0, "R8", "pulses after discarded edge",
              pulses_seen - base, 0);

        check(exp_q.size() == 0, "R2", "outstanding expected pulses", exp_q.size(), 0);
        finish_run();
    end

endmodule